// File: doc/BRIEF.md
# Register-Immediate ALU with Zero/Equal Condition Flag

This unit is the datapath slice of a small processor that combines an 8-bit register operand with an 8-bit immediate. An operation select picks one of four combining functions: bitwise exclusive-or, bitwise or, bitwise and, or a modulo-256 addition. The unit presents the combined value on `result` and raises `wr_en` so that the external register file stores the value back into the same register. The no-operation instruction is encoded as an or with an immediate of zero, so on that encoding the value written back is the register's own value.

The compare operation writes nothing back. It matches the register against the immediate and records the outcome in a one-bit condition flag that the unit owns and clocks. Zero and equal are the same condition, so this single flag serves both the branch-if-zero and the branch-if-equal tests. The comparison is done as a subtraction whose difference is tested for zero. A parameter can swap that for a direct equality test. Decode and the register file are outside the unit. No carry or overflow is produced.

The flag is a two-state machine. FLAG_CLEAR means the last compare found a mismatch, or reset has occurred. FLAG_SET means the last compare found a match. The transitions are:
- SET_ON_MATCH: a compare strobe with a match moves the machine to FLAG_SET.
- CLEAR_ON_MISMATCH: a compare strobe with a mismatch moves it to FLAG_CLEAR.
- HOLD: any cycle without a compare strobe keeps the current state.
- RESET: synchronous reset forces FLAG_CLEAR.

Top module: `imm_alu_ccr`

## Requirements
- R1: With `op_sel` = 0 (XOR) and `alu_en` high, `result` equals `reg_val ^ imm_val` and `wr_en` is 1 in the same cycle.
- R2: With `op_sel` = 1 (OR) and `alu_en` high, `result` equals `reg_val | imm_val` and `wr_en` is 1. With `imm_val` = 0x00 (the no-operation encoding), `result` equals `reg_val` unchanged.
- R3: With `op_sel` = 2 (AND) and `alu_en` high, `result` equals `reg_val & imm_val` and `wr_en` is 1.
- R4: With `op_sel` = 3 (ADD) and `alu_en` high, `result` equals `(reg_val + imm_val) mod 256`, with no carry output, and `wr_en` is 1.
- R5: With `op_sel` = 4 (CMP), `wr_en` is 0 and `result` equals `reg_val`, so the register is not altered.
- R6: A clock edge with `alu_en` high and `op_sel` = 4 sets `zero_eq_flag` to 1 when `reg_val` equals `imm_val` (difference zero) and to 0 otherwise. The new value is visible after that edge.
- R7: `zero_eq_flag` is unchanged across any clock edge where `alu_en` is low or `op_sel` is not 4. This includes an ADD whose result is zero.
- R8: A clock edge with `rst` high clears `zero_eq_flag` to 0.
- R9: Op codes 5, 6 and 7 are undefined. They give `wr_en` = 0 and `result` = `reg_val`, and they leave the flag unchanged.
- R10: `wr_en` is 0 whenever `alu_en` is low, for every op code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the flag |
| alu_en | input | 1 | Execute strobe for the current operation |
| op_sel | input | 3 | Operation: 0 XOR, 1 OR, 2 AND, 3 ADD, 4 CMP, 5-7 undefined |
| reg_val | input | 8 | Register operand |
| imm_val | input | 8 | Immediate operand |
| result | output | 8 | Value to store back into the register |
| wr_en | output | 1 | Write-back request for `result` |
| zero_eq_flag | output | 1 | Registered zero/equal condition flag |

## Verification
Each combining operation is applied to several operand pairs: all-ones against alternating bits, equal operands, and zero immediates. These patterns separate the four functions from one another and reveal a swapped op code. The add is driven across the 8-bit boundary (0xFF+0x01 and 0x80+0x80), which shows whether it wraps or leaks a carry. Compare is tried with equal and unequal operands, with the strobe low, and next to an add that produces zero, which shows whether the flag follows the compare alone. Undefined op codes and a reset taken while the flag is set complete the set.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_XOR = 3'd0,
        OP_OR  = 3'd1,
        OP_AND = 3'd2,
        OP_ADD = 3'd3,
        OP_CMP = 3'd4,
        OP_RS5 = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } alu_op_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

    function automatic logic op_writes_back(alu_op_e op);
        return (op == OP_XOR) || (op == OP_OR) || (op == OP_AND) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/imm_alu_combine.sv
module imm_alu_combine
    import imm_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic [DATA_W-1:0]   comb_out
);

    logic [DATA_W-1:0] sum_wrap;

    // Truncating add: the carry out is dropped by the operand width.
    assign sum_wrap = opa + opb;

    always_comb begin
        unique case (op)
            OP_XOR:  comb_out = opa ^ opb;
            OP_OR:   comb_out = opa | opb;
            OP_AND:  comb_out = opa & opb;
            OP_ADD:  comb_out = sum_wrap;
            default: comb_out = opa;
        endcase
    end

endmodule

// File: rtl/imm_alu_match.sv
module imm_alu_match #(
    parameter int DATA_W     = 8,
    parameter bit CMP_BY_SUB = 1'b1
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              is_match
);

    generate
        if (CMP_BY_SUB) begin : g_sub
            logic [DATA_W-1:0] diff;
            assign diff     = lhs - rhs;
            assign is_match = (diff == '0);
        end else begin : g_eq
            assign is_match = (lhs == rhs);
        end
    endgenerate

endmodule

// File: rtl/imm_alu_flag_fsm.sv
module imm_alu_flag_fsm
    import imm_alu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmp_strobe,
    input  logic cmp_match,
    output logic flag_out
);

    flag_state_e state_q;
    flag_state_e state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (cmp_strobe && cmp_match)  state_d = FLAG_SET;   // SET_ON_MATCH
            FLAG_SET:   if (cmp_strobe && !cmp_match) state_d = FLAG_CLEAR; // CLEAR_ON_MISMATCH
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_CLEAR;                                       // RESET
        else     state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            FLAG_SET: flag_out = 1'b1;
            default:  flag_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/imm_alu_ccr.sv
module imm_alu_ccr
    import imm_alu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit CMP_BY_SUB = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_en,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] imm_val,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              zero_eq_flag
);

    alu_op_e           op;
    logic [DATA_W-1:0] comb_val;
    logic              match;
    logic              strobe_cmp;

    assign op = alu_op_e'(op_sel);

    imm_alu_combine #(.DATA_W(DATA_W)) u_combine (
        .op       (op),
        .opa      (reg_val),
        .opb      (imm_val),
        .comb_out (comb_val)
    );

    imm_alu_match #(.DATA_W(DATA_W), .CMP_BY_SUB(CMP_BY_SUB)) u_match (
        .lhs      (reg_val),
        .rhs      (imm_val),
        .is_match (match)
    );

    assign strobe_cmp = alu_en && (op == OP_CMP);

    imm_alu_flag_fsm u_flag (
        .clk        (clk),
        .rst        (rst),
        .cmp_strobe (strobe_cmp),
        .cmp_match  (match),
        .flag_out   (zero_eq_flag)
    );

    assign result = comb_val;
    assign wr_en  = alu_en && op_writes_back(op);

endmodule

// File: rtl/imm_alu_ccr_chk.sv
module imm_alu_ccr_chk
    import imm_alu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit CMP_BY_SUB = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              alu_en,
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] reg_val,
    input logic [DATA_W-1:0] imm_val,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              zero_eq_flag
);

    logic past_valid;
    always_ff @(posedge clk) past_valid <= 1'b1;

    assert_nop_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd1 && imm_val == '0) |-> (result == reg_val));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd4) |-> (!wr_en && result == reg_val));

    assert_flag_update_R6: assert property (@(posedge clk) disable iff (rst)
        (alu_en && op_sel == 3'd4) |=> (zero_eq_flag == $past(reg_val == imm_val)));

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(alu_en && op_sel == 3'd4) |=> $stable(zero_eq_flag));

    assert_reset_clear_R8: assert property (@(posedge clk)
        (past_valid && $past(rst)) |-> !zero_eq_flag);

    assert_undef_op_R9: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 3'd4) |-> (!wr_en && result == reg_val));

    assert_en_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !alu_en |-> !wr_en);

endmodule

bind imm_alu_ccr imm_alu_ccr_chk #(.DATA_W(DATA_W), .CMP_BY_SUB(CMP_BY_SUB)) u_chk (.*);

// File: tb/imm_alu_ccr_tb.sv
`timescale 1ns/1ps
module imm_alu_ccr_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       alu_en;
    logic [2:0] op_sel;
    logic [7:0] reg_val;
    logic [7:0] imm_val;
    logic [7:0] result;
    logic       wr_en;
    logic       zero_eq_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    imm_alu_ccr u_dut (
        .clk          (clk),
        .rst          (rst),
        .alu_en       (alu_en),
        .op_sel       (op_sel),
        .reg_val      (reg_val),
        .imm_val      (imm_val),
        .result       (result),
        .wr_en        (wr_en),
        .zero_eq_flag (zero_eq_flag)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Combinational op: drive at negedge, sample 2 ns later
    task automatic run_op(input string tag, input logic [2:0] op, input logic [7:0] r,
                          input logic [7:0] i, input logic en,
                          input logic [7:0] exp_res, input logic exp_wr);
        @(negedge clk);
        alu_en = en; op_sel = op; reg_val = r; imm_val = i;
        #2;
        check({tag, " result"}, result, exp_res);
        check({tag, " wr_en"}, {7'd0, wr_en}, {7'd0, exp_wr});
    endtask

    // One clocked cycle with stimulus, then flag observed after the edge
    task automatic run_clocked(input string tag, input logic [2:0] op, input logic [7:0] r,
                               input logic [7:0] i, input logic en, input logic exp_flag);
        @(negedge clk);
        alu_en = en; op_sel = op; reg_val = r; imm_val = i;
        @(posedge clk);
        #1 alu_en = 1'b0;
        @(negedge clk);
        check({tag, " flag"}, {7'd0, zero_eq_flag}, {7'd0, exp_flag});
    endtask

    task automatic test_reset();
        rst = 1'b1; alu_en = 1'b0; op_sel = 3'd0; reg_val = 8'h00; imm_val = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset state", {7'd0, zero_eq_flag}, 8'd0);
        rst = 1'b0;
    endtask

    task automatic test_xor();
        run_op("R1 xor ff^55", 3'd0, 8'hFF, 8'h55, 1'b1, 8'hAA, 1'b1);
        run_op("R1 xor equal", 3'd0, 8'h3C, 8'h3C, 1'b1, 8'h00, 1'b1);
    endtask

    task automatic test_or();
        run_op("R2 or", 3'd1, 8'hA0, 8'h05, 1'b1, 8'hA5, 1'b1);
        run_op("R2 nop", 3'd1, 8'h6B, 8'h00, 1'b1, 8'h6B, 1'b1);
    endtask

    task automatic test_and();
        run_op("R3 and", 3'd2, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1);
        run_op("R3 and ff", 3'd2, 8'h5A, 8'hFF, 1'b1, 8'h5A, 1'b1);
    endtask

    task automatic test_add();
        run_op("R4 add", 3'd3, 8'h12, 8'h34, 1'b1, 8'h46, 1'b1);
        run_op("R4 add wrap ff+01", 3'd3, 8'hFF, 8'h01, 1'b1, 8'h00, 1'b1);
        run_op("R4 add wrap 80+80", 3'd3, 8'h80, 8'h80, 1'b1, 8'h00, 1'b1);
    endtask

    task automatic test_cmp();
        run_op("R5 cmp no write", 3'd4, 8'h77, 8'h10, 1'b1, 8'h77, 1'b0);
        run_clocked("R6 cmp equal", 3'd4, 8'h42, 8'h42, 1'b1, 1'b1);
        run_clocked("R6 cmp unequal", 3'd4, 8'h42, 8'h43, 1'b1, 1'b0);
        run_clocked("R6 cmp equal zero", 3'd4, 8'h00, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic test_hold();
        // flag is 1 here
        run_clocked("R7 add zero result", 3'd3, 8'hFF, 8'h01, 1'b1, 1'b1);
        run_clocked("R7 xor", 3'd0, 8'h01, 8'h02, 1'b1, 1'b1);
        run_clocked("R7 cmp disabled", 3'd4, 8'h01, 8'h02, 1'b0, 1'b1);
        run_clocked("R6 cmp clears", 3'd4, 8'h01, 8'h02, 1'b1, 1'b0);
        run_clocked("R7 cmp disabled match", 3'd4, 8'h09, 8'h09, 1'b0, 1'b0);
    endtask

    task automatic test_undef();
        for (int k = 5; k < 8; k++) begin
            run_op("R9 undefined op", 3'(k), 8'h9C, 8'h63, 1'b1, 8'h9C, 1'b0);
            run_clocked("R9 undefined flag", 3'(k), 8'h11, 8'h11, 1'b1, 1'b0);
        end
    endtask

    task automatic test_enable();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            alu_en = 1'b0; op_sel = 3'(k); reg_val = 8'h01; imm_val = 8'h02;
            #2;
            check("R10 wr_en gated", {7'd0, wr_en}, 8'd0);
        end
    endtask

    task automatic test_reset_clears();
        run_clocked("R6 set before reset", 3'd4, 8'h55, 8'h55, 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset clears set flag", {7'd0, zero_eq_flag}, 8'd0);
    endtask

    initial begin
        test_reset();
        test_xor();
        test_or();
        test_and();
        test_add();
        test_cmp();
        test_hold();
        test_undef();
        test_enable();
        test_reset_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule